// File: doc/BRIEF.md
# ADC Conversion Flow Controller

This block sequences the conversion flow of an analog-to-digital converter in response to four kinds of control request: restart, trigger, sequence abort and load-ok. Every request can come as a single-cycle pulse from the register-write path or from an internal hardware interface. The two sources of each kind are merged into one request per cycle. The block keeps three status flags: a restart in progress, a pending trigger and an abort in progress. A request that arrives while its own flag is still set is an overrun, and each request kind handles overrun in its own way.

Restart overruns are kept in a single-entry pending register, where the latest one overwrites any earlier one. Each restart overrun also samples the load-ok input into a shadow bit. When the running restart completes, the pending one starts. A trigger overrun raises a sticky error flag and stops conversion through a halt output. How fast the halt comes depends on the overrun: normally at the next conversion boundary, but at once when a restart-generated trigger in trigger mode meets an external trigger. Abort overruns are dropped. The converter core is outside this block. It supplies a restart-complete pulse, an abort-complete pulse, a sampling-start pulse and a conversion-boundary pulse.

Top module: `adc_flow_ctrl`

## Requirements
- R1: A restart pulse on `bus_restart` or `hw_restart` while `restart_busy` and `restart_queued` are both 0 sets `restart_busy` on the next clock edge.
- R2: A restart pulse while `restart_busy` is 1 sets `restart_queued` on the next edge. Any number of such overruns leave exactly one queued restart, so after the queued restart runs and completes, `restart_busy` stays 0.
- R3: A `restart_done` pulse while `restart_busy` is 1 clears `restart_busy` on the next edge. If a restart is queued, or a restart pulse arrives in that same cycle, `restart_queued` is 1 after that edge. On the following edge `restart_busy` returns to 1 and `restart_queued` clears.
- R4: On each restart overrun, `ldok_shadow` takes the value of `load_ok`, so it holds the value from the latest overrun. It clears on the edge where the queued restart starts.
- R5: A trigger pulse on `bus_trig` or `hw_trig` while `trig_pend` is 1 sets `trig_err` on the next edge. `halt` rises on the edge that ends the first cycle, at or after that overrun, in which `conv_boundary` is 1.
- R6: With `trig_mode` = 1, a restart that starts (fresh or queued) in the same cycle as an external trigger pulse sets both `trig_err` and `halt` on the next edge, with no conversion boundary needed.
- R7: With `trig_mode` = 1, every restart start sets `trig_pend`. A restart overrun never sets `trig_err`.
- R8: An abort pulse on `bus_abort` or `hw_abort` while `abort_busy` is 0 sets `abort_busy`. An abort pulse while `abort_busy` is 1 is dropped. One `abort_done` pulse clears `abort_busy`, and it stays 0.
- R9: `trig_err` stays 1 until an `err_clr` pulse clears it on the next edge. `halt` is 1 only while `trig_err` is 1, and it stays 1 until that clear.
- R10: `rst` = 1 at a clock edge clears all flags, the queued restart, `ldok_shadow`, `trig_err` and `halt`.
- R11: A trigger pulse sets `trig_pend` on the next edge. A `sample_start` pulse with no trigger in the same cycle clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_mode | input | 1 | 1 = each restart start also issues a hardware trigger |
| bus_restart | input | 1 | Restart pulse from register writes |
| hw_restart | input | 1 | Restart pulse from internal interface |
| bus_trig | input | 1 | Trigger pulse from register writes |
| hw_trig | input | 1 | Trigger pulse from internal interface |
| bus_abort | input | 1 | Abort pulse from register writes |
| hw_abort | input | 1 | Abort pulse from internal interface |
| load_ok | input | 1 | Load-ok level sampled on restart overrun |
| restart_done | input | 1 | Converter finished the running restart |
| abort_done | input | 1 | Converter finished the running abort |
| sample_start | input | 1 | Converter starts sampling (consumes trigger) |
| conv_boundary | input | 1 | Converter is at a conversion boundary |
| err_clr | input | 1 | Write-one-to-clear pulse for the trigger error |
| restart_busy | output | 1 | Restart in progress |
| restart_queued | output | 1 | One restart overrun is waiting |
| ldok_shadow | output | 1 | Load-ok captured with the latest restart overrun |
| trig_pend | output | 1 | Trigger pending |
| abort_busy | output | 1 | Abort in progress |
| trig_err | output | 1 | Sticky trigger-overrun error |
| halt | output | 1 | Stop command to the converter |

## Verification
The risky coincidences are a restart completion meeting a new restart request, and, in trigger mode, a restart start meeting an external trigger. The bench drives each pair in the same cycle. It then checks that the request became queued rather than lost, and that the halt came with no boundary. A long pseudo-random sweep puts requests, completions and load-ok in every combination. It compares the restart flags and the shadow each cycle against a model written from R1 to R4.

// File: rtl/adc_flow_pkg.sv
package adc_flow_pkg;

    typedef struct packed {
        logic active;
        logic queued;
        logic ldok;
    } rst_state_t;

    typedef enum logic [1:0] {
        OVR_NONE      = 2'd0,
        OVR_BOUNDARY  = 2'd1,
        OVR_IMMEDIATE = 2'd2
    } trig_ovr_t;

    localparam int unsigned NUM_SRC = 2;

    function automatic logic any_src(input logic [NUM_SRC-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/afc_restart_track.sv
module afc_restart_track
    import adc_flow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       done,
    input  logic       load_ok,
    output rst_state_t st,
    output logic       start
);
    rst_state_t nxt;

    always_comb begin
        nxt   = st;
        start = 1'b0;
        if (st.active) begin
            if (done) nxt.active = 1'b0;
            if (req) begin
                nxt.queued = 1'b1;
                nxt.ldok   = load_ok;
            end
        end else if (st.queued) begin
            start      = 1'b1;
            nxt.active = 1'b1;
            nxt.queued = 1'b0;
            nxt.ldok   = 1'b0;
            if (req) begin
                nxt.queued = 1'b1;
                nxt.ldok   = load_ok;
            end
        end else if (req) begin
            start      = 1'b1;
            nxt.active = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end
endmodule

// File: rtl/afc_trig_track.sv
module afc_trig_track
    import adc_flow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic auto_trig,
    input  logic sample_start,
    input  logic conv_boundary,
    input  logic err_clr,
    output logic pend,
    output logic err,
    output logic halt
);
    trig_ovr_t kind;
    logic      pend_n, err_n, halt_n;

    always_comb begin
        if (auto_trig && trig_in)  kind = OVR_IMMEDIATE;
        else if (trig_in && pend)  kind = OVR_BOUNDARY;
        else                       kind = OVR_NONE;

        pend_n = (pend && !sample_start) || trig_in || auto_trig;
        err_n  = (kind != OVR_NONE) || (err && !err_clr);
        halt_n = (kind == OVR_IMMEDIATE) ||
                 (err_n && ((halt && !err_clr) || conv_boundary));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            err  <= 1'b0;
            halt <= 1'b0;
        end else begin
            pend <= pend_n;
            err  <= err_n;
            halt <= halt_n;
        end
    end
endmodule

// File: rtl/afc_abort_track.sv
module afc_abort_track (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic done,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst)       busy <= 1'b0;
        else if (busy) busy <= !done;
        else           busy <= req;
    end
endmodule

// File: rtl/adc_flow_ctrl.sv
module adc_flow_ctrl
    import adc_flow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_mode,
    input  logic bus_restart,
    input  logic hw_restart,
    input  logic bus_trig,
    input  logic hw_trig,
    input  logic bus_abort,
    input  logic hw_abort,
    input  logic load_ok,
    input  logic restart_done,
    input  logic abort_done,
    input  logic sample_start,
    input  logic conv_boundary,
    input  logic err_clr,
    output logic restart_busy,
    output logic restart_queued,
    output logic ldok_shadow,
    output logic trig_pend,
    output logic abort_busy,
    output logic trig_err,
    output logic halt
);
    logic       restart_req, trig_req, abort_req;
    logic       restart_start;
    rst_state_t rs;

    assign restart_req = any_src({bus_restart, hw_restart});
    assign trig_req    = any_src({bus_trig, hw_trig});
    assign abort_req   = any_src({bus_abort, hw_abort});

    afc_restart_track u_restart (
        .clk     (clk),
        .rst     (rst),
        .req     (restart_req),
        .done    (restart_done),
        .load_ok (load_ok),
        .st      (rs),
        .start   (restart_start)
    );

    afc_trig_track u_trig (
        .clk           (clk),
        .rst           (rst),
        .trig_in       (trig_req),
        .auto_trig     (restart_start && trig_mode),
        .sample_start  (sample_start),
        .conv_boundary (conv_boundary),
        .err_clr       (err_clr),
        .pend          (trig_pend),
        .err           (trig_err),
        .halt          (halt)
    );

    afc_abort_track u_abort (
        .clk  (clk),
        .rst  (rst),
        .req  (abort_req),
        .done (abort_done),
        .busy (abort_busy)
    );

    assign restart_busy   = rs.active;
    assign restart_queued = rs.queued;
    assign ldok_shadow    = rs.ldok;
endmodule

// File: rtl/adc_flow_ctrl_chk.sv
module adc_flow_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic restart_req,
    input logic trig_req,
    input logic abort_req,
    input logic restart_done,
    input logic abort_done,
    input logic err_clr,
    input logic trig_mode,
    input logic restart_busy,
    input logic restart_queued,
    input logic ldok_shadow,
    input logic trig_err,
    input logic halt,
    input logic abort_busy
);
    assert_fresh_restart_R1: assert property (@(posedge clk) disable iff (rst)
        (!restart_busy && !restart_queued && restart_req) |=> restart_busy);

    assert_overrun_queued_R2: assert property (@(posedge clk) disable iff (rst)
        (restart_busy && restart_req) |=> restart_queued);

    assert_queued_service_R3: assert property (@(posedge clk) disable iff (rst)
        (!restart_busy && restart_queued && !restart_req)
            |=> (restart_busy && !restart_queued));

    assert_shadow_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        (!restart_busy && restart_queued && !restart_req) |=> !ldok_shadow);

    assert_no_restart_err_R7: assert property (@(posedge clk) disable iff (rst)
        (trig_mode && restart_busy && restart_req && !trig_req && !trig_err)
            |=> !trig_err);

    assert_abort_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (abort_busy && !abort_done) |=> abort_busy);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (trig_err && !err_clr) |=> trig_err);

    assert_halt_needs_err_R9: assert property (@(posedge clk) disable iff (rst)
        halt |-> trig_err);

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!abort_busy && !abort_req) |=> !abort_busy);
endmodule

bind adc_flow_ctrl adc_flow_ctrl_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .restart_req    (restart_req),
    .trig_req       (trig_req),
    .abort_req      (abort_req),
    .restart_done   (restart_done),
    .abort_done     (abort_done),
    .err_clr        (err_clr),
    .trig_mode      (trig_mode),
    .restart_busy   (restart_busy),
    .restart_queued (restart_queued),
    .ldok_shadow    (ldok_shadow),
    .trig_err       (trig_err),
    .halt           (halt),
    .abort_busy     (abort_busy)
);

// File: tb/adc_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_flow_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, trig_mode, bus_restart, hw_restart, bus_trig, hw_trig;
    logic bus_abort, hw_abort, load_ok, restart_done, abort_done;
    logic sample_start, conv_boundary, err_clr;
    logic restart_busy, restart_queued, ldok_shadow, trig_pend;
    logic abort_busy, trig_err, halt;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_flow_ctrl dut_i (.*);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        bus_restart = 0; hw_restart = 0; bus_trig = 0; hw_trig = 0;
        bus_abort = 0; hw_abort = 0; restart_done = 0; abort_done = 0;
        sample_start = 0; conv_boundary = 0; err_clr = 0;
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic do_reset();
        idle_in();
        rst = 1; cyc(); cyc(); rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic m_act, m_q, m_ld, rq;
        logic [15:0] lfsr;
        trig_mode = 0; load_ok = 0;
        do_reset();
        // R10 reset state
        chk(restart_busy, 0, "R10 restart_busy"); chk(restart_queued, 0, "R10 queued");
        chk(ldok_shadow, 0, "R10 shadow"); chk(trig_pend, 0, "R10 trig_pend");
        chk(abort_busy, 0, "R10 abort_busy"); chk(trig_err, 0, "R10 trig_err");
        chk(halt, 0, "R10 halt");

        // R1 fresh restart via bus
        bus_restart = 1; cyc(); idle_in();
        chk(restart_busy, 1, "R1 bus restart sets busy");
        chk(restart_queued, 0, "R1 no queue");
        // R2 / R4 two overruns, latest load_ok kept
        hw_restart = 1; load_ok = 1; cyc(); idle_in();
        chk(restart_queued, 1, "R2 overrun queued"); chk(ldok_shadow, 1, "R4 shadow=1");
        bus_restart = 1; load_ok = 0; cyc(); idle_in();
        chk(ldok_shadow, 0, "R4 shadow latest=0"); chk(restart_queued, 1, "R2 still one");
        // R3 service
        restart_done = 1; cyc(); idle_in();
        chk(restart_busy, 0, "R3 busy drops"); chk(restart_queued, 1, "R3 queued held");
        cyc();
        chk(restart_busy, 1, "R3 busy again"); chk(restart_queued, 0, "R3 queue cleared");
        chk(ldok_shadow, 0, "R4 shadow cleared");
        restart_done = 1; cyc(); idle_in(); cyc();
        chk(restart_busy, 0, "R2 only one queued restart");

        // R4 shadow cleared on service when it was 1
        hw_restart = 1; cyc(); idle_in();
        bus_restart = 1; load_ok = 1; cyc(); idle_in(); load_ok = 0;
        chk(ldok_shadow, 1, "R4 shadow captured");
        // R3 request coinciding with done
        restart_done = 1; cyc(); idle_in();
        cyc();
        chk(ldok_shadow, 0, "R4 cleared on service");
        restart_done = 1; hw_restart = 1; cyc(); idle_in();
        chk(restart_busy, 0, "R3 coincident busy low"); chk(restart_queued, 1, "R3 coincident queued");
        cyc();
        chk(restart_busy, 1, "R3 coincident serviced");
        restart_done = 1; cyc(); idle_in();

        // R11 trigger pend set and clear
        bus_trig = 1; cyc(); idle_in();
        chk(trig_pend, 1, "R11 trig sets pend");
        sample_start = 1; cyc(); idle_in();
        chk(trig_pend, 0, "R11 sample clears pend");
        // R5 trigger overrun, halt at boundary
        hw_trig = 1; cyc(); idle_in();
        chk(trig_err, 0, "R5 first trig no err");
        bus_trig = 1; cyc(); idle_in();
        chk(trig_err, 1, "R5 overrun err"); chk(halt, 0, "R5 no halt before boundary");
        cyc(); chk(halt, 0, "R5 still no halt");
        conv_boundary = 1; cyc(); idle_in();
        chk(halt, 1, "R5 halt at boundary");
        cyc(); cyc();
        chk(trig_err, 1, "R9 err sticky"); chk(halt, 1, "R9 halt held");
        err_clr = 1; cyc(); idle_in();
        chk(trig_err, 0, "R9 err cleared"); chk(halt, 0, "R9 halt cleared");
        sample_start = 1; cyc(); idle_in();

        // R7 trigger mode: start sets pend, overrun no err
        trig_mode = 1;
        bus_restart = 1; cyc(); idle_in();
        chk(trig_pend, 1, "R7 restart start sets pend");
        sample_start = 1; cyc(); idle_in();
        hw_restart = 1; cyc(); idle_in();
        chk(trig_err, 0, "R7 restart overrun no err"); chk(trig_pend, 0, "R7 overrun no auto trig");
        restart_done = 1; cyc(); idle_in();
        cyc();
        chk(trig_pend, 1, "R7 queued start sets pend");
        chk(trig_err, 0, "R7 still no err");
        restart_done = 1; sample_start = 1; cyc(); idle_in();
        // R6 coincident start and trigger
        bus_restart = 1; hw_trig = 1; cyc(); idle_in();
        chk(trig_err, 1, "R6 coincident err"); chk(halt, 1, "R6 immediate halt");
        err_clr = 1; restart_done = 1; sample_start = 1; cyc(); idle_in();
        trig_mode = 0;
        chk(halt, 0, "R9 clear after R6");

        // R8 abort
        bus_abort = 1; cyc(); idle_in();
        chk(abort_busy, 1, "R8 abort set");
        hw_abort = 1; cyc(); idle_in();
        chk(abort_busy, 1, "R8 overrun held");
        abort_done = 1; bus_abort = 1; cyc(); idle_in();
        chk(abort_busy, 0, "R8 cleared by done");
        cyc();
        chk(abort_busy, 0, "R8 overrun dropped");

        // R10 reset mid-operation
        bus_restart = 1; bus_trig = 1; bus_abort = 1; cyc();
        hw_restart = 1; hw_trig = 1; load_ok = 1; cyc(); idle_in(); load_ok = 0;
        rst = 1; cyc(); rst = 0;
        chk(restart_busy, 0, "R10 busy"); chk(restart_queued, 0, "R10 queue");
        chk(ldok_shadow, 0, "R10 shadow"); chk(trig_err, 0, "R10 err");
        chk(trig_pend, 0, "R10 pend"); chk(abort_busy, 0, "R10 abort");

        // sweep of restart flow against model of R1..R4
        m_act = 0; m_q = 0; m_ld = 0; lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_restart = lfsr[0] & lfsr[3]; hw_restart = lfsr[5] & lfsr[7];
            restart_done = lfsr[9]; load_ok = lfsr[11];
            rq = bus_restart | hw_restart;
            if (m_act) begin
                if (restart_done) m_act = 0;
                if (rq) begin m_q = 1; m_ld = load_ok; end
            end else if (m_q) begin
                m_act = 1; m_q = 0; m_ld = 0;
                if (rq) begin m_q = 1; m_ld = load_ok; end
            end else if (rq) m_act = 1;
            cyc();
            chk(restart_busy, m_act, "R1 sweep busy");
            chk(restart_queued, m_q, "R2 sweep queued");
            chk(ldok_shadow, m_ld, "R4 sweep shadow");
        end
        idle_in();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule